// File: doc/BRIEF.md
# Dithering Oversampled Serial Receiver

This block recovers 8-bit characters from one asynchronous, idle-high serial line. It does not use a fixed divide-by-sixteen. Software sets a clocks-per-bit count N, and the receiver times every bit from that count. Each bit is decided by a majority of three samples: the clock at the bit centre, floor(N/2) clocks after the bit begins, and the clocks on either side of it.

A 10-bit stretch mask gives one flag per frame position. Position 0 is the start bit, positions 1 to 8 are the data bits and position 9 is the stop bit. A set flag makes that position one clock longer. Spreading such extra clocks over a frame brings the average bit rate close to a target that is not an integer division of the clock.

When the stop bit has been decided, the receiver delivers the byte and a framing-error flag together with a single-cycle strobe. It then goes back to watching for a new start.

Top module: `uart_rx_dither`

## Requirements
- R1: While reset is asserted and directly after it, data_o is 0, valid_o is 0 and ferr_o is 0.
- R2: The serial input passes through two synchroniser flops. A high-to-low change on the synchronised line, seen while the receiver is idle, starts a frame. The clock in which that change is visible counts as clock 0 of the start bit.
- R3: The start bit is accepted only if the majority of its three samples is low. Otherwise the receiver returns to idle with no strobe. With N=16, a low pulse of 8 clocks is rejected and a low pulse of 9 clocks is accepted.
- R4: Each bit takes the majority of its three samples. A single sample that disagrees with the other two does not change the decided value.
- R5: A bit of length L starts L clocks after the previous bit starts. Samples are taken at offsets floor(N/2)-1, floor(N/2) and floor(N/2)+1 from the bit start. With N=16 and no stretch, the start bit is sampled on clocks 7, 8 and 9 and the first data bit on clocks 23, 24 and 25.
- R6: Mask bit i (bit 0 = start bit, bit 9 = stop bit) makes frame position i last N+1 clocks instead of N. The strobe moves later by one clock for each set mask bit among positions 0 to 8.
- R7: Data bits arrive least significant first. The first data bit received lands in data_o[0].
- R8: ferr_o is 1 when the decided stop bit is 0, and 0 when it is 1. It is updated only with the strobe.
- R9: valid_o is high for exactly one clock. It rises 3 clocks after the decision clock of the stop bit, counted from the input change that began the frame. data_o and ferr_o change only in a strobe cycle and hold their values otherwise.
- R10: A clocks-per-bit value below 3 is treated as 3.
- R11: After the stop decision the receiver is idle at once. A falling edge that coincides with the strobe cycle starts the next frame. A line held low after a frame starts no new frame until it has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| cpb_i | input | 8 | Clocks per bit N (values below 3 act as 3) |
| mask_i | input | 10 | Per-position stretch flags, bit 0 = start, bit 9 = stop |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-clock strobe marking a new byte |
| ferr_o | output | 1 | Stop bit of the last byte was decided low |

## Verification
The stop-bit decision and the start of the next frame can fall in the same cycle. The strobe cycle is also the first clock in which the receiver is idle again, so a falling edge seen in that clock must both leave the byte intact and be taken as a new start. The bench provokes this by shortening a stop bit to floor(N/2)+2 clocks and driving the next start bit immediately afterwards. It then judges both bytes, their error flags and the exact strobe cycle of each, computed from N and the mask.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line_o,
  output logic line_d_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              line_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q  <= {STAGES{RESET_VAL}};
      line_d_q <= RESET_VAL;
    end else begin
      chain_q  <= {chain_q[STAGES-2:0], din};
      line_d_q <= chain_q[STAGES-1];
    end
  end

  assign line_o   = chain_q[STAGES-1];
  assign line_d_o = line_d_q;
  assign fall_o   = line_d_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int CPB_W      = 8,
  parameter int FRAME_BITS = 10,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int CNT_W     = CPB_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active_i,
  input  logic                  clr_i,
  input  logic [CPB_W-1:0]      cpb_i,
  input  logic [FRAME_BITS-1:0] mask_i,
  output logic [POS_W-1:0]      pos_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [CNT_W-1:0]      len_o,
  output logic                  samp_o,
  output logic                  decide_o
);

  logic [CNT_W-1:0] n_eff, centre, len;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic             stretch, last, upd;

  assign n_eff   = (cpb_i < CPB_W'(3)) ? CNT_W'(3) : {1'b0, cpb_i};
  assign centre  = n_eff >> 1;
  assign stretch = mask_i[pos_q];
  assign len     = n_eff + {{(CNT_W-1){1'b0}}, stretch};
  assign last    = (cnt_q == len - CNT_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    pos_n = pos_q;
    if (clr_i || !active_i) begin
      cnt_n = '0;
      pos_n = '0;
    end else if (last) begin
      cnt_n = '0;
      pos_n = pos_q + POS_W'(1);
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  assign upd = clr_i | active_i | (cnt_q != '0) | (pos_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_n;
      pos_q <= pos_n;
    end
  end

  assign samp_o   = active_i & ((cnt_q == centre - CNT_W'(1)) | (cnt_q == centre));
  assign decide_o = active_i & (cnt_q == centre + CNT_W'(1));
  assign pos_o    = pos_q;
  assign cnt_o    = cnt_q;
  assign len_o    = len;

endmodule

// File: rtl/uart_rx_dither.sv
module uart_rx_dither #(
  parameter int  CPB_W       = 8,
  parameter int  DATA_BITS   = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int FRAME_BITS  = DATA_BITS + 2,
  localparam int POS_W       = $clog2(FRAME_BITS),
  localparam int CNT_W       = CPB_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_i,
  input  logic [CPB_W-1:0]      cpb_i,
  input  logic [FRAME_BITS-1:0] mask_i,
  output logic [DATA_BITS-1:0]  data_o,
  output logic                  valid_o,
  output logic                  ferr_o
);
  import uart_rx_pkg::*;

  rx_state_e            state_q, state_n;
  logic                 line, line_d, fall;
  logic                 active, clr, samp, decide, bit_val;
  logic                 sh_ld, out_ld, busy;
  logic [1:0]           smp_q;
  logic [DATA_BITS-1:0] shift_q;
  logic [POS_W-1:0]     pos;
  logic [CNT_W-1:0]     cnt, len;

  rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (rx_i),
    .line_o   (line),
    .line_d_o (line_d),
    .fall_o   (fall)
  );

  assign busy   = (state_q == RX_RUN);
  assign active = busy | fall;

  rx_bit_timer #(.CPB_W(CPB_W), .FRAME_BITS(FRAME_BITS)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .clr_i    (clr),
    .cpb_i    (cpb_i),
    .mask_i   (mask_i),
    .pos_o    (pos),
    .cnt_o    (cnt),
    .len_o    (len),
    .samp_o   (samp),
    .decide_o (decide)
  );

  assign bit_val = vote3(smp_q[1], smp_q[0], line);

  always_comb begin
    state_n = state_q;
    clr     = 1'b0;
    sh_ld   = 1'b0;
    out_ld  = 1'b0;
    case (state_q)
      RX_IDLE: if (fall) state_n = RX_RUN;
      RX_RUN: begin
        if (decide) begin
          if (pos == '0) begin
            if (bit_val) begin
              state_n = RX_IDLE;
              clr     = 1'b1;
            end
          end else if (pos == POS_W'(FRAME_BITS - 1)) begin
            state_n = RX_IDLE;
            clr     = 1'b1;
            out_ld  = 1'b1;
          end else begin
            sh_ld = 1'b1;
          end
        end
      end
      default: state_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      valid_o <= 1'b0;
    end else begin
      state_q <= state_n;
      valid_o <= out_ld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
    end else if (samp) begin
      smp_q <= {smp_q[0], line};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (sh_ld) begin
      shift_q <= {bit_val, shift_q[DATA_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      ferr_o <= 1'b0;
    end else if (out_ld) begin
      data_o <= shift_q;
      ferr_o <= ~bit_val;
    end
  end

endmodule

// File: rtl/rx_dither_checks.sv
module rx_dither_checks #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_o,
  input logic              ferr_o,
  input logic [DATA_W-1:0] data_o,
  input logic              busy,
  input logic              line,
  input logic              line_d,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  len
);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o) else $error("valid wider than one clock"); // R9

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(data_o)) else $error("data changed without strobe"); // R9

  AST_FERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(ferr_o)) else $error("ferr changed without strobe"); // R8

  AST_CNT_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len)) else $error("bit counter past bit length"); // R6

  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(line_d) && !$past(line))) else $error("frame began without edge"); // R2

  AST_STROBE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(busy)) else $error("strobe while idle"); // R11

endmodule

bind uart_rx_dither rx_dither_checks i_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid_o (valid_o),
  .ferr_o  (ferr_o),
  .data_o  (data_o),
  .busy    (busy),
  .line    (line),
  .line_d  (line_d),
  .cnt     (cnt),
  .len     (len)
);

// File: tb/test_uart_rx_dither.sv
module test_uart_rx_dither;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx;
  logic [7:0] cpb;
  logic [9:0] mask;
  logic [7:0] data_o;
  logic       valid_o, ferr_o;

  uart_rx_dither i_uart_rx_dither (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .cpb_i(cpb), .mask_i(mask),
    .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int pcnt = 0;
  always @(posedge clk) pcnt <= pcnt + 1;

  int nchk = 0, nerr = 0;
  int got = 0, vrun = 0, vmax = 0, nexp = 0;
  logic [7:0] rec_d [64];
  logic       rec_f [64];
  int         rec_k [64];

  always @(negedge clk) begin
    if (rst_n === 1'b1 && valid_o === 1'b1) begin
      if (got < 64) begin
        rec_d[got] = data_o;
        rec_f[got] = ferr_o;
        rec_k[got] = pcnt;
      end
      got++;
      vrun++;
      if (vrun > vmax) vmax = vrun;
    end else begin
      vrun = 0;
    end
  end

  always @(posedge clk) begin
    if (pcnt == WD_LIMIT) begin
      nerr++;
      $display("FAIL watchdog (all): got %0d cycles, exp below %0d", pcnt, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int frame_lat(input int n, input logic [9:0] m);
    int ne, s;
    ne = (n < 3) ? 3 : n;
    s  = 0;
    for (int i = 0; i < 9; i++) s += ne + int'(m[i]);
    return s + ne / 2 + 1 + 3;
  endfunction

  task automatic hold(input logic v, input int cyc);
    rx = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stopv, input int n,
                            input logic [9:0] m, input int gpos, input int stop_len,
                            output int k0);
    int ne, c, len;
    logic bv;
    ne   = (n < 3) ? 3 : n;
    c    = ne / 2;
    cpb  = 8'(n);
    mask = m;
    k0   = pcnt;
    for (int i = 0; i < 10; i++) begin
      bv  = (i == 0) ? 1'b0 : (i == 9) ? stopv : b[i-1];
      len = ne + int'(m[i]);
      if (i == 9 && stop_len > 0) len = stop_len;
      if (i == gpos) begin
        hold(bv, c);
        hold(~bv, 1);
        hold(bv, len - c - 1);
      end else begin
        hold(bv, len);
      end
    end
  endtask

  task automatic sync_mon();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input int idx, input logic [7:0] eb, input logic ef,
                             input int ek, input string req);
    sync_mon();
    chk(got > idx, $sformatf("%s frame %0d present: got %0d strobes, exp > %0d", req, idx, got, idx));
    if (got > idx) begin
      chk(rec_d[idx] == eb, $sformatf("%s data: got %02h exp %02h", req, rec_d[idx], eb));
      chk(rec_f[idx] == ef, $sformatf("%s ferr: got %0b exp %0b", req, rec_f[idx], ef));
      chk(rec_k[idx] == ek, $sformatf("%s strobe cycle: got %0d exp %0d", req, rec_k[idx], ek));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rx = 1'b1; cpb = 8'd16; mask = '0;
    repeat (3) @(negedge clk);
    chk(data_o == 8'h00 && valid_o == 1'b0 && ferr_o == 1'b0,
        $sformatf("R1 reset outputs: got %02h/%0b/%0b exp 00/0/0", data_o, valid_o, ferr_o));
    rst_n = 1'b1;
    hold(1'b1, 10);
    chk(data_o == 8'h00 && valid_o == 1'b0 && ferr_o == 1'b0,
        $sformatf("R1 after release: got %02h/%0b/%0b exp 00/0/0", data_o, valid_o, ferr_o));
  endtask

  task automatic t_basic();
    int k0;
    send_frame(8'hA5, 1'b1, 16, 10'h000, -1, -1, k0);
    hold(1'b1, 20);
    check_frame(nexp, 8'hA5, 1'b0, k0 + frame_lat(16, 10'h000), "R5 R7 default rate");
    nexp++;
  endtask

  task automatic t_lsb();
    int k0;
    send_frame(8'h01, 1'b1, 5, 10'h000, -1, -1, k0);
    hold(1'b1, 20);
    check_frame(nexp, 8'h01, 1'b0, k0 + frame_lat(5, 10'h000), "R7 lsb first");
    nexp++;
  endtask

  task automatic t_dither();
    int k0;
    send_frame(8'h3C, 1'b1, 10, 10'h355, -1, -1, k0);
    hold(1'b1, 20);
    check_frame(nexp, 8'h3C, 1'b0, k0 + frame_lat(10, 10'h355), "R6 stretch mask");
    nexp++;
    send_frame(8'hE1, 1'b1, 3, 10'h3FF, -1, -1, k0);
    hold(1'b1, 20);
    check_frame(nexp, 8'hE1, 1'b0, k0 + frame_lat(3, 10'h3FF), "R6 all stretched at N=3");
    nexp++;
  endtask

  task automatic t_glitch();
    int k0;
    send_frame(8'h96, 1'b1, 16, 10'h000, 3, -1, k0);
    hold(1'b1, 20);
    check_frame(nexp, 8'h96, 1'b0, k0 + frame_lat(16, 10'h000), "R4 data glitch");
    nexp++;
    send_frame(8'h4B, 1'b1, 12, 10'h000, 0, -1, k0);
    hold(1'b1, 20);
    check_frame(nexp, 8'h4B, 1'b0, k0 + frame_lat(12, 10'h000), "R4 start glitch");
    nexp++;
  endtask

  task automatic t_start_reject();
    int g, k0;
    cpb = 8'd16; mask = '0;
    sync_mon();
    g = got;
    hold(1'b0, 8);
    hold(1'b1, 200);
    sync_mon();
    chk(got == g, $sformatf("R3 8-clock pulse rejected: got %0d strobes exp %0d", got, g));
    k0 = pcnt;
    hold(1'b0, 9);
    hold(1'b1, 200);
    check_frame(nexp, 8'hFF, 1'b0, k0 + frame_lat(16, 10'h000), "R3 9-clock pulse accepted");
    nexp++;
  endtask

  task automatic t_ferr();
    int k0, g;
    send_frame(8'h5A, 1'b0, 16, 10'h000, -1, -1, k0);
    hold(1'b0, 60);
    check_frame(nexp, 8'h5A, 1'b1, k0 + frame_lat(16, 10'h000), "R8 stop low");
    nexp++;
    g = got;
    chk(g == nexp, $sformatf("R11 no start while line stays low: got %0d exp %0d", g, nexp));
    chk(data_o == 8'h5A && ferr_o == 1'b1,
        $sformatf("R9 outputs held: got %02h/%0b exp 5a/1", data_o, ferr_o));
    hold(1'b1, 40);
    send_frame(8'hC3, 1'b1, 16, 10'h000, -1, -1, k0);
    hold(1'b1, 20);
    check_frame(nexp, 8'hC3, 1'b0, k0 + frame_lat(16, 10'h000), "R11 recover after break");
    nexp++;
  endtask

  task automatic t_clamp();
    int k0;
    send_frame(8'h69, 1'b1, 1, 10'h000, -1, -1, k0);
    hold(1'b1, 20);
    check_frame(nexp, 8'h69, 1'b0, k0 + frame_lat(3, 10'h000), "R10 N=1 acts as 3");
    nexp++;
  endtask

  task automatic t_b2b();
    int k0, k1;
    send_frame(8'h11, 1'b1, 8, 10'h000, -1, 8 / 2 + 2, k0);
    send_frame(8'hEE, 1'b1, 8, 10'h000, -1, -1, k1);
    hold(1'b1, 20);
    chk(k1 == k0 + frame_lat(8, 10'h000) - 2,
        $sformatf("R11 next edge meets strobe cycle: got %0d exp %0d", k1, k0 + frame_lat(8, 10'h000) - 2));
    check_frame(nexp, 8'h11, 1'b0, k0 + frame_lat(8, 10'h000), "R11 first of pair");
    nexp++;
    check_frame(nexp, 8'hEE, 1'b0, k1 + frame_lat(8, 10'h000), "R11 second of pair");
    nexp++;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lsb();
    t_dither();
    t_glitch();
    t_start_reject();
    t_ferr();
    t_clamp();
    t_b2b();
    sync_mon();
    chk(got == nexp, $sformatf("R3 strobe total: got %0d exp %0d", got, nexp));
    chk(vmax == 1, $sformatf("R9 strobe width: got %0d exp 1", vmax));
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule